// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the input divider and feedback divider for a phase-locked loop, given a reference clock and the wanted PHY bit clock, both as whole numbers in kHz. The legal input dividers are those that keep the divided reference between 5 MHz and 40 MHz. The block first works out that range. It then steps through the candidates one at a time. For each one it computes the feedback ratio and its fractional remainder, and it keeps the candidate whose remainder is smallest. A candidate is only eligible while its feedback divider stays below 512.

When the search ends, the block computes the feedback divider for the chosen input divider. It then computes the clock that this pair actually produces, and presents both together with the encoded values a PHY configuration port expects. All arithmetic runs through one shared shift-and-subtract divider, one quotient bit per cycle. A pulse on `start` launches a run. A one-cycle `done` pulse marks its end, and the results stay stable until the next run completes. If the legal range is empty, `err` is raised and no divider pair is produced.

Top module: `pll_div_search`

## Requirements
- R1: The upper bound is floor(ref/5000). The lower bound is floor(ref/40000)+1. Candidates run from the lower bound up to the upper bound minus one.
- R2: If the upper bound is below the lower bound, the run ends with err=1 and with prediv, fbdiv and achieved_khz all 0.
- R3: A candidate i becomes the new best only when (tgt*i) mod ref is strictly below the best remainder so far and floor(tgt*i/ref) is below 512. The best remainder starts at ref, so on equal remainders the earlier, smaller divider is kept.
- R4: If no candidate qualifies, prediv is 1.
- R5: fbdiv = floor(tgt*prediv/ref) and achieved_khz = floor(ref*fbdiv/prediv). On a successful run err is 0.
- R6: pre_code is the low 8 bits of prediv-1. fb_lo is bits 4:0 of fbdiv-1, and fb_hi is bits 8:5 of fbdiv-1.
- R7: done is high for exactly one cycle per run. busy is high from the cycle after an accepted start until done. The results do not change while busy is low.
- R8: A start that arrives while busy is high is ignored. Its reference and target values have no effect on the result of the run in progress.
- R9: After reset, busy, done and err are 0, and prediv, fbdiv and achieved_khz are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only when idle |
| ref_khz | input | W | Reference clock in kHz |
| tgt_khz | input | W | Wanted PHY bit clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Legal input-divider range was empty |
| prediv | output | W | Chosen input divider |
| fbdiv | output | W | Feedback divider |
| achieved_khz | output | W | Clock produced by the chosen pair |
| pre_code | output | 8 | prediv-1 |
| fb_lo | output | 5 | Low 5 bits of fbdiv-1 |
| fb_hi | output | 4 | Bits 8:5 of fbdiv-1 |

## Verification
The bench uses one reference and target pair where only the last candidate divides exactly. This shows that the search really keeps the smallest remainder and does not stop at the first fit. A second case gives every candidate a zero remainder, so the result separates strict from non-strict comparison and also checks the nonzero lower bound. Further cases cover an empty range (error), a range with no candidates (default divider), and a target so high that every candidate breaks the 512 ceiling. A final run changes the inputs and raises start while busy, which shows whether a second start can disturb the run in progress.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int W          = 24,
  parameter int LO_REF_KHZ = 5000,
  parameter int HI_REF_KHZ = 40000,
  parameter int FB_LIMIT   = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] ref_khz,
  input  logic [W-1:0] tgt_khz,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] prediv,
  output logic [W-1:0] fbdiv,
  output logic [W-1:0] achieved_khz,
  output logic [7:0]   pre_code,
  output logic [4:0]   fb_lo,
  output logic [3:0]   fb_hi
);
  localparam int PW   = 2 * W;
  localparam int CNTW = $clog2(PW + 1);

  typedef enum logic [2:0] {PH_HI, PH_LO, PH_NEXT, PH_CAND, PH_FB, PH_ACH} phase_t;

  phase_t         ph;
  logic [W-1:0]   ref_q, tgt_q, hi_q, lo_q, cand, best, best_rem, fb_q;
  logic [PW-1:0]  d_num;
  logic [W-1:0]   d_den, d_rem;
  logic [CNTW-1:0] d_cnt;
  logic [W:0]     trial;
  logic           fits;
  logic [W-1:0]   lo_new;
  logic [W-1:0]   pm1, fm1;

  assign trial  = {d_rem, d_num[PW-1]};
  assign fits   = trial >= {1'b0, d_den};
  assign lo_new = d_num[W-1:0] + 1'b1;
  assign pm1    = prediv - 1'b1;
  assign fm1    = fbdiv - 1'b1;
  assign pre_code = pm1[7:0];
  assign fb_lo    = fm1[4:0];
  assign fb_hi    = fm1[8:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      prediv <= '0; fbdiv <= '0; achieved_khz <= '0;
      ph <= PH_HI; ref_q <= '0; tgt_q <= '0; hi_q <= '0; lo_q <= '0;
      cand <= '0; best <= '0; best_rem <= '0; fb_q <= '0;
      d_num <= '0; d_den <= '0; d_rem <= '0; d_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          ref_q <= ref_khz;
          tgt_q <= tgt_khz;
          ph    <= PH_HI;
          d_num <= PW'(ref_khz);
          d_den <= W'(LO_REF_KHZ);
          d_rem <= '0;
          d_cnt <= CNTW'(PW);
        end
      end else if (d_cnt != '0) begin
        d_rem <= fits ? W'(trial - {1'b0, d_den}) : trial[W-1:0];
        d_num <= {d_num[PW-2:0], fits};
        d_cnt <= d_cnt - 1'b1;
      end else begin
        case (ph)
          PH_HI: begin
            hi_q  <= d_num[W-1:0];
            ph    <= PH_LO;
            d_num <= PW'(ref_q);
            d_den <= W'(HI_REF_KHZ);
            d_rem <= '0;
            d_cnt <= CNTW'(PW);
          end
          PH_LO: begin
            lo_q <= lo_new;
            if (hi_q < lo_new) begin
              err <= 1'b1; done <= 1'b1; busy <= 1'b0;
              prediv <= '0; fbdiv <= '0; achieved_khz <= '0;
            end else begin
              best     <= W'(1);
              best_rem <= ref_q;
              cand     <= lo_new;
              ph       <= PH_NEXT;
            end
          end
          PH_NEXT: begin
            d_den <= ref_q;
            d_rem <= '0;
            d_cnt <= CNTW'(PW);
            if (cand < hi_q) begin
              d_num <= PW'(tgt_q) * PW'(cand);
              ph    <= PH_CAND;
            end else begin
              d_num <= PW'(tgt_q) * PW'(best);
              ph    <= PH_FB;
            end
          end
          PH_CAND: begin
            if (d_rem < best_rem && d_num < PW'(FB_LIMIT)) begin
              best     <= cand;
              best_rem <= d_rem;
            end
            cand <= cand + 1'b1;
            ph   <= PH_NEXT;
          end
          PH_FB: begin
            fb_q  <= d_num[W-1:0];
            d_num <= PW'(ref_q) * PW'(d_num[W-1:0]);
            d_den <= best;
            d_rem <= '0;
            d_cnt <= CNTW'(PW);
            ph    <= PH_ACH;
          end
          default: begin
            prediv       <= best;
            fbdiv        <= fb_q;
            achieved_khz <= d_num[W-1:0];
            err  <= 1'b0;
            done <= 1'b1;
            busy <= 1'b0;
          end
        endcase
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(prediv) && $stable(fbdiv) && $stable(achieved_khz) && $stable(err)));
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (prediv == '0 && fbdiv == '0 && achieved_khz == '0 && hi_q < lo_q));
  a_r3_fb_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && prediv != W'(1)) |-> (fbdiv < W'(FB_LIMIT)));
  a_r1_pick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (prediv == W'(1) || (prediv >= lo_q && prediv < hi_q)));
  a_r5_achieved_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (achieved_khz <= tgt_q));
endmodule

// File: tb/test_pll_div_search.sv
module test_pll_div_search;
  localparam int W = 24;
  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] ref_khz = '0, tgt_khz = '0;
  logic busy, done, err;
  logic [W-1:0] prediv, fbdiv, achieved_khz;
  logic [7:0] pre_code;
  logic [4:0] fb_lo;
  logic [3:0] fb_hi;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pll_div_search #(.W(W)) i_pll_div_search (
    .clk, .rst_n, .start, .ref_khz, .tgt_khz, .busy, .done, .err,
    .prediv, .fbdiv, .achieved_khz, .pre_code, .fb_lo, .fb_hi);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input longint r, input longint t, output bit e,
                       output longint p, output longint f, output longint a);
    longint hi, lo, rem;
    hi = r / 5000; lo = r / 40000 + 1;
    e = hi < lo; p = 0; f = 0; a = 0;
    if (!e) begin
      p = 1; rem = r;
      for (longint i = lo; i < hi; i++)
        if ((t * i) % r < rem && (t * i) / r < 512) begin p = i; rem = (t * i) % r; end
      f = t * p / r;
      a = r * f / p;
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) chk("R7 watchdog", 0, 1);
  endtask

  task automatic launch(input longint r, input longint t);
    @(negedge clk);
    ref_khz = W'(r); tgt_khz = W'(t); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic check_result(input string tag, input longint r, input longint t);
    bit e, ok; longint p, f, a;
    model(r, t, e, p, f, a);
    wait_done(ok);
    if (ok) begin
      chk({tag, " R2/R5 err"}, err, e);
      chk({tag, " R3 prediv"}, prediv, p);
      chk({tag, " R5 fbdiv"}, fbdiv, f);
      chk({tag, " R5 achieved"}, achieved_khz, a);
      if (!e) begin
        chk({tag, " R6 pre_code"}, pre_code, (p - 1) & 8'hff);
        chk({tag, " R6 fb_lo"}, fb_lo, (f - 1) & 5'h1f);
        chk({tag, " R6 fb_hi"}, fb_hi, ((f - 1) >> 5) & 4'hf);
      end
      @(negedge clk);
      chk({tag, " R7 done one cycle"}, done, 0);
      repeat (3) @(negedge clk);
      chk({tag, " R7 held"}, prediv, p);
      chk({tag, " R7 idle"}, busy, 0);
    end
  endtask

  task automatic t_reset;
    chk("R9 busy", busy, 0); chk("R9 done", done, 0); chk("R9 err", err, 0);
    chk("R9 prediv", prediv, 0); chk("R9 fbdiv", fbdiv, 0); chk("R9 achieved", achieved_khz, 0);
  endtask

  task automatic t_best_last;  // R3: exact fit only at the last candidate
    launch(24000, 1000000);
    chk("R7 busy after start", busy, 1);
    check_result("best_last", 24000, 1000000);
    chk("R3 best_last prediv 3", prediv, 3);
  endtask

  task automatic t_ties;  // R1 nonzero lower bound, R3 ties keep smallest
    launch(40000, 1000000);
    check_result("ties", 40000, 1000000);
    chk("R1 R3 ties prediv 2", prediv, 2);
  endtask

  task automatic t_empty;  // R2
    launch(4000, 800000);
    check_result("empty", 4000, 800000);
    chk("R2 err raised", err, 1);
  endtask

  task automatic t_no_cand;  // R4: range 1..0 has no candidates
    launch(5000, 600000);
    check_result("no_cand", 5000, 600000);
    chk("R4 default prediv", prediv, 1);
  endtask

  task automatic t_ceiling;  // R3/R4: every candidate breaks 512
    launch(10000, 6000000);
    check_result("ceiling", 10000, 6000000);
    chk("R4 ceiling prediv", prediv, 1);
    chk("R4 ceiling fbdiv", fbdiv, 600);
  endtask

  task automatic t_restart_ignored;  // R8
    launch(24000, 1000000);
    repeat (10) @(negedge clk);
    ref_khz = W'(40000); tgt_khz = W'(410000); start = 1;
    @(negedge clk);
    start = 0;
    check_result("R8 ignored", 24000, 1000000);
  endtask

  task automatic t_mixed;  // R5 general pair
    launch(26000, 912345);
    check_result("mixed", 26000, 912345);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_best_last;
    t_ties;
    t_empty;
    t_no_cand;
    t_ceiling;
    t_restart_ignored;
    t_mixed;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule